// File: doc/BRIEF.md
# Sixteen-Pin Memory-Mapped I/O Port

This block is one general-purpose I/O port of sixteen pins, each set up on its own through a small word-addressed register bus. Per pin, software picks a mode (input, general output, alternate function, analog), a driver style (push-pull or open-drain), a pull resistor and a drive-speed level. The block turns these settings into pad controls: an output value, an output enable, pull-up and pull-down enables and a speed code for each pin.

Pin levels pass through a two-stage synchronizer into a read-only input register. Output values live in a read/write output register. They can also be changed through a write-only set/clear register, so one pin can be flipped without a read-modify-write that an interrupt could break. A peripheral clock-enable input gates all register access. A placeholder input supplies the value driven by pins in alternate-function mode.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration register and the output register read 0. No pin is output-enabled and no pull is enabled.
- R2: The mode register (word 0) has 2 bits per pin at bit 2*pin: 00 input, 01 general output, 10 alternate function, 11 analog. Only output and alternate-function pins are ever output-enabled.
- R3: The driver-style register (word 1, bit pin, 0 push-pull, 1 open-drain) shapes the output enable. A push-pull pin in a driving mode is always enabled. An open-drain pin is enabled only while its driven value is 0.
- R4: The pull register (word 3) has 2 bits per pin at bit 2*pin: 01 enables the pull-up, 10 enables the pull-down, 00 and 11 enable neither. An analog pin has no pull enabled.
- R5: The speed register (word 2) has 2 bits per pin, reads back as written and appears on the speed output.
- R6: The input register (word 4) is read-only and shows each pin's level two rising clock edges after it changes. Writes to it are ignored.
- R7: The output register (word 5) is read/write through its low 16 bits. Its bits are the values driven by general-output pins.
- R8: A write to the set/clear register (word 6) sets output bit n for each 1 in bit n, and clears output bit n for each 1 in bit n+16. Bits written as 0 leave the output unchanged.
- R9: When one set/clear write has both the set and the clear bit for the same pin, the pin ends up set.
- R10: Reading the set/clear register returns 0.
- R11: While the clock enable is low, writes change nothing and reads return 0.
- R12: A pin in alternate-function mode drives the matching bit of the alternate input rather than its output register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Peripheral clock enable; gates register access |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| pin_in | input | 16 | Raw pin levels |
| alt_out | input | 16 | Values for pins in alternate-function mode |
| pin_out | output | 16 | Value presented to each pad |
| pin_oe | output | 16 | Output enable for each pad |
| pull_up | output | 16 | Pull-up enable for each pad |
| pull_dn | output | 16 | Pull-down enable for each pad |
| pad_speed | output | 32 | Speed code, 2 bits per pin |

## Verification
The hardest case to reach from the ports is a set/clear write that carries the set and clear bits for the same pin together, on top of an output register that already mixes ones and zeros. Without that, set priority and the "zero means unchanged" rule cannot be seen apart. The stimulus table therefore walks one output register through a chained run of direct writes and set/clear writes, and checks the stored value after each step. The open-drain enable is reached the same way: a pin is switched to open-drain while its output bit is 1, and is then cleared through the set/clear register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS   = 16;
  localparam int DW     = 32;
  localparam int IDX_W  = 3;
  localparam int FLD_W  = 2 * PINS;

  localparam logic [IDX_W-1:0] REG_MODE  = 3'd0;
  localparam logic [IDX_W-1:0] REG_OTYPE = 3'd1;
  localparam logic [IDX_W-1:0] REG_SPEED = 3'd2;
  localparam logic [IDX_W-1:0] REG_PULL  = 3'd3;
  localparam logic [IDX_W-1:0] REG_IDR   = 3'd4;
  localparam logic [IDX_W-1:0] REG_ODR   = 3'd5;
  localparam logic [IDX_W-1:0] REG_SR    = 3'd6;

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pin_pull_e;

  // set wins over clear: clear first, then OR in the set half
  function automatic logic [PINS-1:0] sr_apply(input logic [PINS-1:0] cur,
                                                input logic [FLD_W-1:0] w);
    return (cur & ~w[FLD_W-1:PINS]) | w[PINS-1:0];
  endfunction

  function automatic logic pad_enable(input pin_mode_e m, input logic od,
                                      input logic val);
    logic drives;
    drives = (m == MODE_OUT) || (m == MODE_ALT);
    return drives && (!od || !val);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;
  logic [1:0]   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      warm   <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign synced = stage2;

  // R6: input register lags the pin by exactly two edges
  assert_sync_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (synced == $past(raw, 2)));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [PINS-1:0]  idr,
  output logic [DW-1:0]    bus_rdata,
  output logic [FLD_W-1:0] mode_q,
  output logic [PINS-1:0]  otype_q,
  output logic [FLD_W-1:0] speed_q,
  output logic [FLD_W-1:0] pull_q,
  output logic [PINS-1:0]  odr_q
);
  logic wr_en;
  logic rd_en;
  logic sr_write;

  assign wr_en    = bus_sel && bus_wr && clk_en;
  assign rd_en    = bus_sel && !bus_wr && clk_en;
  assign sr_write = wr_en && (bus_addr == REG_SR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        REG_MODE:  mode_q  <= bus_wdata[FLD_W-1:0];
        REG_OTYPE: otype_q <= bus_wdata[PINS-1:0];
        REG_SPEED: speed_q <= bus_wdata[FLD_W-1:0];
        REG_PULL:  pull_q  <= bus_wdata[FLD_W-1:0];
        REG_ODR:   odr_q   <= bus_wdata[PINS-1:0];
        REG_SR:    odr_q   <= sr_apply(odr_q, bus_wdata[FLD_W-1:0]);
        default:   ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        REG_MODE:  bus_rdata = DW'(mode_q);
        REG_OTYPE: bus_rdata = DW'(otype_q);
        REG_SPEED: bus_rdata = DW'(speed_q);
        REG_PULL:  bus_rdata = DW'(pull_q);
        REG_IDR:   bus_rdata = DW'(idr);
        REG_ODR:   bus_rdata = DW'(odr_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R8/R9: every set bit ends up 1
  assert_sr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write |=> ((odr_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));
  // R8: a clear bit without its set bit ends up 0
  assert_sr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write |=> ((odr_q & $past(bus_wdata[FLD_W-1:PINS]) & ~$past(bus_wdata[PINS-1:0])) == '0));
  // R8: untouched bits keep their value
  assert_sr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_write |=> (((odr_q ^ $past(odr_q)) & ~($past(bus_wdata[FLD_W-1:PINS]) | $past(bus_wdata[PINS-1:0]))) == '0));
  // R11: no state change while the clock enable is low
  assert_gated_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(mode_q) && $stable(otype_q) && $stable(speed_q)
                 && $stable(pull_q) && $stable(odr_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pkg::*;
(
  input  logic [FLD_W-1:0] mode_q,
  input  logic [PINS-1:0]  otype_q,
  input  logic [FLD_W-1:0] pull_q,
  input  logic [PINS-1:0]  odr_q,
  input  logic [PINS-1:0]  alt_out,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pull_up,
  output logic [PINS-1:0]  pull_dn
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e m;
    pin_pull_e p;
    logic      drive_val;

    assign m         = pin_mode_e'(mode_q[2*i +: 2]);
    assign p         = pin_pull_e'(pull_q[2*i +: 2]);
    assign drive_val = (m == MODE_ALT) ? alt_out[i] : odr_q[i];
    assign pin_out[i] = drive_val;
    assign pin_oe[i]  = pad_enable(m, otype_q[i], drive_val);
    assign pull_up[i] = (m != MODE_ANA) && (p == PULL_UP);
    assign pull_dn[i] = (m != MODE_ANA) && (p == PULL_DOWN);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  input  logic [PINS-1:0]  alt_out,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic [PINS-1:0]  pull_up,
  output logic [PINS-1:0]  pull_dn,
  output logic [FLD_W-1:0] pad_speed
);
  logic [PINS-1:0]  idr;
  logic [FLD_W-1:0] mode_q;
  logic [PINS-1:0]  otype_q;
  logic [FLD_W-1:0] speed_q;
  logic [FLD_W-1:0] pull_q;
  logic [PINS-1:0]  odr_q;

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(idr)
  );

  gpio_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .idr(idr), .bus_rdata(bus_rdata),
    .mode_q(mode_q), .otype_q(otype_q), .speed_q(speed_q),
    .pull_q(pull_q), .odr_q(odr_q)
  );

  gpio_pad_ctl u_pad (
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odr_q(odr_q),
    .alt_out(alt_out), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );

  assign pad_speed = speed_q;

  // R3: an open-drain pin never actively drives a 1
  assert_od_no_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & otype_q & pin_out) == '0));
  // R11: reads return zero while the clock enable is low
  assert_gated_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (bus_rdata == '0));
  // R1: the cycle after reset releases, nothing drives or pulls
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pull_up == '0 && pull_dn == '0));

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    // R2: input and analog pins are never output-enabled
    assert_quiet_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == MODE_IN || mode_q[2*i +: 2] == MODE_ANA) |-> !pin_oe[i]);
    // R4: analog pins have no pull, and never both pulls
    assert_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == MODE_ANA) |-> (!pull_up[i] && !pull_dn[i]));
    assert_pull_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_up[i] && pull_dn[i]));
  end
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] alt_out = '0;
  logic [15:0] pin_out, pin_oe, pull_up, pull_dn;
  logic [31:0] pad_speed;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up),
    .pull_dn(pull_dn), .pad_speed(pad_speed)
  );

  // {word index, write data, expected output register}
  localparam logic [50:0] TBL [8] = '{
    {3'd5, 32'h0000_00F0, 16'h00F0},
    {3'd6, 32'h0000_0003, 16'h00F3},
    {3'd6, 32'h0010_0000, 16'h00E3},
    {3'd6, 32'h0001_0001, 16'h00E3},
    {3'd6, 32'h0000_0000, 16'h00E3},
    {3'd6, 32'hFFFF_0000, 16'h0000},
    {3'd5, 32'hFFFF_1234, 16'h1234},
    {3'd6, 32'h8000_8001, 16'h9235}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] idx, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    rd_now(idx, d);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < 7; k++) begin
      rd(3'(k), d);
      check("R1 register after reset", d, 32'h0);
    end
    check("R1 no output enable", {16'h0, pin_oe}, 32'h0);
    check("R1 no pulls", {pull_up, pull_dn}, 32'h0);

    // R7 R8 R9: output register table
    for (int k = 0; k < 8; k++) begin
      wr(TBL[k][50:48], TBL[k][47:16]);
      rd(3'd5, d);
      check("R7 R8 R9 table", d, {16'h0, TBL[k][15:0]});
    end

    // R2: pin 3 as general output
    wr(3'd0, 32'h0000_0040);
    wr(3'd5, 32'h0000_0008);
    check("R2 output enable", {16'h0, pin_oe}, 32'h0008);
    check("R2 output value", {16'h0, pin_out}, 32'h0008);

    // R3: open-drain with output 1 floats, with 0 drives
    wr(3'd1, 32'hFFFF_0008);
    check("R3 open-drain high floats", {16'h0, pin_oe}, 32'h0000);
    rd(3'd1, d);
    check("R3 driver-style readback", d, 32'h0000_0008);
    wr(3'd6, 32'h0008_0000);
    check("R3 open-drain low drives", {16'h0, pin_oe}, 32'h0008);
    check("R3 open-drain value", {16'h0, pin_out}, 32'h0000);

    // R12: pin 5 alternate, push-pull
    alt_out = 16'h0020;
    wr(3'd0, 32'h0000_0840);
    check("R12 alternate enable", {16'h0, pin_oe}, 32'h0028);
    check("R12 alternate value", {16'h0, pin_out}, 32'h0020);
    alt_out = 16'h0000;
    #1 check("R12 alternate follows input", {16'h0, pin_out}, 32'h0000);

    // R4: pulls on input pins 0..2, then analog pin 0
    wr(3'd3, 32'h0000_0039);
    check("R4 pull-up", {16'h0, pull_up}, 32'h0001);
    check("R4 pull-down", {16'h0, pull_dn}, 32'h0002);
    wr(3'd0, 32'h0000_0843);
    check("R4 analog drops pull", {16'h0, pull_up}, 32'h0000);

    // R5: speed
    wr(3'd2, 32'hC000_0003);
    rd(3'd2, d);
    check("R5 speed readback", d, 32'hC000_0003);
    check("R5 speed output", pad_speed, 32'hC000_0003);

    // R6: two-edge synchronizer, read-only
    @(negedge clk);
    pin_in = 16'hA5A5;
    rd_now(3'd4, d);
    check("R6 no edge yet", d, 32'h0);
    rd(3'd4, d);
    check("R6 one edge", d, 32'h0);
    rd(3'd4, d);
    check("R6 two edges", d, 32'h0000_A5A5);
    wr(3'd4, 32'h0000_FFFF);
    rd(3'd4, d);
    check("R6 write ignored", d, 32'h0000_A5A5);

    // R10: set/clear reads zero
    wr(3'd6, 32'h0000_0100);
    rd(3'd6, d);
    check("R10 set/clear reads zero", d, 32'h0);

    // R11: gated access
    clk_en = 1'b0;
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd0, 32'h5555_5555);
    rd(3'd5, d);
    check("R11 gated read", d, 32'h0);
    clk_en = 1'b1;
    rd(3'd5, d);
    check("R11 gated write ignored", d, 32'h0000_0100);
    rd(3'd0, d);
    check("R11 gated mode kept", d, 32'h0000_0843);

    finished = 1;
    summary();
  end
endmodule